// File: doc/BRIEF.md
# Graphics Control and Interrupt-Mask Register

This block is the control/status register pair at the front of a graphics rasterizer. Software reaches it through a plain 32-bit register port. The control word means one thing when written and another when read. A write acknowledges and re-enables five event sources, suspends or resumes drawing, and can issue a soft reset. A read returns the pending-event flags, the display field flags, a FIFO fill code and two fixed identification bytes.

A second register, 0x10 bytes above the control word, holds one mask bit per event source. The block takes single-cycle event pulses, horizontal and vertical sync strobes, and the live FIFO empty and almost-full levels. It drives a level interrupt and one-cycle flush and soft-reset command pulses to the drawing engine and the FIFO. It also drives a level that holds drawing while a flush is in effect.

Addresses are byte offsets from the parameter `CTL_OFS`, which defaults to 0. The control word is at +0x00, a read-only zero word is at +0x04, and the mask register is at +0x10. Any other address reads zero and ignores writes. Reads are combinational on `addr`.

Top module: `gfx_ctl_regs`

## Requirements
- R1: After reset, the control word reads 0x551B0000 ORed with the current FIFO code, so 0x551B4000 while the FIFO is empty. The mask register reads 0x00007F00, and `irq`, `flush_pulse`, `sreset_pulse` and `draw_hold` are 0.
- R2: Each event has a pending bit in the control word: bit 0 signal, bit 1 finish, bit 2 hsync strobe, bit 3 vsync strobe, bit 4 rect-area-write end. A pulse on an event input sets its bit on the next clock edge, and the bit stays set until it is acknowledged.
- R3: Writing the control word with a 1 in any of bits 4:0 clears that pending bit, and a 0 leaves the bit unchanged. If an event pulse arrives in the same cycle as its acknowledge, the bit stays set.
- R4: A write to the mask register keeps only bits 12:8, which are the masks for sources 0..4 in the R2 order. The mask register reads those five bits at 12:8, reads bits 14:13 as 1, and reads every other bit as 0.
- R5: `irq` is 1 exactly when some pending bit has a clear mask bit. Setting a mask bit hides its source but does not clear the pending bit.
- R6: A control write with bit 8 set produces a single-cycle `flush_pulse` in the next cycle and sets `draw_hold`. A control write with bit 8 clear clears `draw_hold`. Bits 8 and 9 always read back 0.
- R7: A control write with bit 9 set produces a single-cycle `sreset_pulse`. In that same cycle every mask bit reads 1, and the pending bits are untouched.
- R8: Each vsync strobe toggles bit 13 (the current field: 0 even, 1 odd). On the same edge, bit 12 captures the value that bit 13 held before the toggle.
- R9: Control bits 15:14 give the FIFO code: 01 when the FIFO is empty (this takes priority), 10 when it is almost full, and 00 otherwise. The code 11 never appears.
- R10: Control bits 23:16 read 0x1B and bits 31:24 read 0x55. Bits 11:10 and 7:5 read 0. The word at +0x04 and every unmapped address read 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe for one cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational on addr |
| ev_signal | input | 1 | Signal event pulse |
| ev_finish | input | 1 | Finish event pulse |
| ev_rect_done | input | 1 | Rect-area-write end pulse |
| hsync | input | 1 | Horizontal sync strobe |
| vsync | input | 1 | Vertical sync strobe |
| fifo_empty | input | 1 | FIFO empty level |
| fifo_afull | input | 1 | FIFO almost-full level |
| irq | output | 1 | Level interrupt |
| flush_pulse | output | 1 | One-cycle flush command |
| sreset_pulse | output | 1 | One-cycle soft-reset command |
| draw_hold | output | 1 | Drawing suspended by flush |

## Verification
The assertions assume that all event inputs and sync strobes are synchronous to `clk`. They also assume that a write targets only one address per cycle, so an acknowledge and a mask write never land together. They place no limit on how often events arrive or on the FIFO levels, and the stimulus uses that freedom. Random cycles fire each event with probability 1/8, which makes event-versus-acknowledge collisions common. They also drive both FIFO levels high at the same time so that the empty-first priority is exercised. Writes are aimed at the control word, the mask register, the zero word and an unmapped address, with fully random data.

// File: rtl/gfxc_pkg.sv
package gfxc_pkg;
   localparam int NSRC      = 5;
   localparam int B_FLUSH   = 8;
   localparam int B_SRST    = 9;
   localparam int B_NFLD    = 12;
   localparam int B_FLD     = 13;
   localparam int MSK_LSB   = 8;
   localparam int OFS_HI    = 4;
   localparam int OFS_MSK   = 16;

   typedef enum logic [1:0] {
      FIFO_MID   = 2'b00,
      FIFO_EMPTY = 2'b01,
      FIFO_AFULL = 2'b10,
      FIFO_RSVD  = 2'b11
   } fifo_code_t;
endpackage

// File: rtl/gfxc_event_bank.sv
module gfxc_event_bank #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] ack,
   output logic [N-1:0] pend
);
   if (N < 1) begin : g_bad_n
      $error("gfxc_event_bank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_src
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= ev[i] | (q & ~ack[i]);
      end
      assign pend[i] = q;
   end
endmodule

// File: rtl/gfxc_field_track.sv
module gfxc_field_track (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync,
   output logic field,
   output logic nfield
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field  <= 1'b0;
         nfield <= 1'b0;
      end else if (vsync) begin
         nfield <= field;
         field  <= ~field;
      end
   end
endmodule

// File: rtl/gfxc_fifo_status.sv
module gfxc_fifo_status
   import gfxc_pkg::*;
#(
   parameter bit EMPTY_WINS = 1'b1
) (
   input  logic       fifo_empty,
   input  logic       fifo_afull,
   output logic [1:0] code
);
   fifo_code_t c;

   if (EMPTY_WINS) begin : g_empty_first
      always_comb begin
         if (fifo_empty)      c = FIFO_EMPTY;
         else if (fifo_afull) c = FIFO_AFULL;
         else                 c = FIFO_MID;
      end
   end else begin : g_afull_first
      always_comb begin
         if (fifo_afull)      c = FIFO_AFULL;
         else if (fifo_empty) c = FIFO_EMPTY;
         else                 c = FIFO_MID;
      end
   end

   assign code = c;
endmodule

// File: rtl/gfxc_cmd_mask.sv
module gfxc_cmd_mask #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctl_wr,
   input  logic         msk_wr,
   input  logic         flush_bit,
   input  logic         srst_bit,
   input  logic [N-1:0] msk_in,
   output logic [N-1:0] mask,
   output logic         flush_pulse,
   output logic         sreset_pulse,
   output logic         draw_hold
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask         <= '1;
         flush_pulse  <= 1'b0;
         sreset_pulse <= 1'b0;
         draw_hold    <= 1'b0;
      end else begin
         flush_pulse  <= ctl_wr & flush_bit;
         sreset_pulse <= ctl_wr & srst_bit;
         if (ctl_wr) draw_hold <= flush_bit;
         if (ctl_wr && srst_bit) mask <= '1;
         else if (msk_wr)        mask <= msk_in;
      end
   end
endmodule

// File: rtl/gfx_ctl_regs.sv
module gfx_ctl_regs
   import gfxc_pkg::*;
#(
   parameter int         ADDR_W     = 8,
   parameter int         CTL_OFS    = 0,
   parameter logic [7:0] REV_VAL    = 8'h1B,
   parameter logic [7:0] ID_VAL     = 8'h55,
   parameter bit         EMPTY_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic              ev_signal,
   input  logic              ev_finish,
   input  logic              ev_rect_done,
   input  logic              hsync,
   input  logic              vsync,
   input  logic              fifo_empty,
   input  logic              fifo_afull,
   output logic              irq,
   output logic              flush_pulse,
   output logic              sreset_pulse,
   output logic              draw_hold
);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_OFS);
   localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(CTL_OFS + OFS_HI);
   localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(CTL_OFS + OFS_MSK);

   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_aw
      $error("gfx_ctl_regs: ADDR_W must be 5..32");
   end
   if (CTL_OFS % 32 != 0 || CTL_OFS < 0) begin : g_bad_ofs
      $error("gfx_ctl_regs: CTL_OFS must be a non-negative multiple of 32");
   end
   if (longint'(CTL_OFS) + OFS_MSK >= (longint'(1) << ADDR_W)) begin : g_bad_fit
      $error("gfx_ctl_regs: mask register does not fit the address space");
   end

   logic            ctl_wr, msk_wr;
   logic [NSRC-1:0] ev_vec, ack_vec, pend_q, mask_q;
   logic            field_q, nfield_q;
   logic [1:0]      fifo_code;

   assign ctl_wr  = wr_en && (addr == A_CTL);
   assign msk_wr  = wr_en && (addr == A_MSK);
   assign ev_vec  = {ev_rect_done, vsync, hsync, ev_finish, ev_signal};
   assign ack_vec = ctl_wr ? wdata[NSRC-1:0] : '0;

   gfxc_event_bank #(.N(NSRC)) u_ev (
      .clk  (clk),
      .rst_n(rst_n),
      .ev   (ev_vec),
      .ack  (ack_vec),
      .pend (pend_q)
   );

   gfxc_field_track u_fld (
      .clk   (clk),
      .rst_n (rst_n),
      .vsync (vsync),
      .field (field_q),
      .nfield(nfield_q)
   );

   gfxc_fifo_status #(.EMPTY_WINS(EMPTY_WINS)) u_fifo (
      .fifo_empty(fifo_empty),
      .fifo_afull(fifo_afull),
      .code      (fifo_code)
   );

   gfxc_cmd_mask #(.N(NSRC)) u_cmd (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr      (ctl_wr),
      .msk_wr      (msk_wr),
      .flush_bit   (wdata[B_FLUSH]),
      .srst_bit    (wdata[B_SRST]),
      .msk_in      (wdata[MSK_LSB +: NSRC]),
      .mask        (mask_q),
      .flush_pulse (flush_pulse),
      .sreset_pulse(sreset_pulse),
      .draw_hold   (draw_hold)
   );

   assign irq = |(pend_q & ~mask_q);

   logic [31:0] ctl_word, msk_word;

   always_comb begin
      ctl_word               = '0;
      ctl_word[NSRC-1:0]     = pend_q;
      ctl_word[B_NFLD]       = nfield_q;
      ctl_word[B_FLD]        = field_q;
      ctl_word[15:14]        = fifo_code;
      ctl_word[23:16]        = REV_VAL;
      ctl_word[31:24]        = ID_VAL;
      msk_word               = '0;
      msk_word[MSK_LSB +: NSRC] = mask_q;
      msk_word[14:13]        = 2'b11;
   end

   always_comb begin
      if (addr == A_CTL)      rdata = ctl_word;
      else if (addr == A_MSK) rdata = msk_word;
      else if (addr == A_HI)  rdata = '0;
      else                    rdata = '0;
   end

   logic unused_wbits;
   assign unused_wbits = ^{wdata[31:13], wdata[7:5]};
endmodule

// File: rtl/gfxc_ctl_chk.sv
module gfxc_ctl_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ctl_wr,
   input logic        msk_wr,
   input logic [31:0] wdata,
   input logic [4:0]  ev_vec,
   input logic [4:0]  pend,
   input logic [4:0]  mask,
   input logic        irq,
   input logic        flush_pulse,
   input logic        sreset_pulse,
   input logic        field,
   input logic        vsync,
   input logic [1:0]  fifo_code
);
   // R2
   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|ev_vec) |=> ((pend & $past(ev_vec)) == $past(ev_vec)));
   // R3
   a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> ((pend & ($past(wdata[4:0]) & ~$past(ev_vec))) == 5'b0));
   // R4
   a_r4_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
      msk_wr |=> (mask == $past(wdata[12:8])));
   // R5
   a_r5_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == 5'h1f) |-> !irq);
   // R6
   a_r6_flush_on: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[8]) |=> flush_pulse);
   a_r6_flush_off: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_wr && wdata[8]) |=> !flush_pulse);
   // R7
   a_r7_sreset_masks: assert property (@(posedge clk) disable iff (!rst_n)
      sreset_pulse |-> (mask == 5'h1f));
   // R8
   a_r8_field_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |=> (field != $past(field)));
   // R9
   a_r9_no_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_code != 2'b11);
endmodule

bind gfx_ctl_regs gfxc_ctl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ctl_wr      (ctl_wr),
   .msk_wr      (msk_wr),
   .wdata       (wdata),
   .ev_vec      (ev_vec),
   .pend        (pend_q),
   .mask        (mask_q),
   .irq         (irq),
   .flush_pulse (flush_pulse),
   .sreset_pulse(sreset_pulse),
   .field       (field_q),
   .vsync       (vsync),
   .fifo_code   (fifo_code)
);

// File: tb/sim_gfx_ctl_regs.sv
`timescale 1ns/1ps
module sim_gfx_ctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        ev_signal = 0, ev_finish = 0, ev_rect_done = 0, hsync = 0, vsync = 0;
   logic        fifo_empty = 1'b1, fifo_afull = 1'b0;
   logic        irq, flush_pulse, sreset_pulse, draw_hold;

   always #2 clk = ~clk;

   gfx_ctl_regs u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rdata(rdata), .ev_signal(ev_signal), .ev_finish(ev_finish),
      .ev_rect_done(ev_rect_done), .hsync(hsync), .vsync(vsync),
      .fifo_empty(fifo_empty), .fifo_afull(fifo_afull), .irq(irq),
      .flush_pulse(flush_pulse), .sreset_pulse(sreset_pulse), .draw_hold(draw_hold)
   );

   int n_chk = 0, n_err = 0;
   bit done = 0;

   // reference state
   logic [4:0] m_pend = '0, m_mask = 5'h1f;
   logic m_field = 0, m_nfield = 0, m_hold = 0, m_flush = 0, m_srst = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_fifo(input logic e, input logic f);
      if (e) return 2'b01;
      if (f) return 2'b10;
      return 2'b00;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      if (a == 8'h00)
         return {8'h55, 8'h1B, exp_fifo(fifo_empty, fifo_afull), m_field, m_nfield, 7'b0, m_pend};
      if (a == 8'h10)
         return {17'b0, 2'b11, m_mask, 8'b0};
      return 32'h0;
   endfunction

   task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic [4:0] ev, input string tag);
      logic ctlw, mskw;
      @(negedge clk);
      wr_en = w; addr = a; wdata = d;
      ev_signal = ev[0]; ev_finish = ev[1]; hsync = ev[2]; vsync = ev[3]; ev_rect_done = ev[4];
      @(posedge clk);
      ctlw = w && (a == 8'h00);
      mskw = w && (a == 8'h10);
      m_pend  = (m_pend & ~(ctlw ? d[4:0] : 5'b0)) | ev;
      if (ctlw && d[9]) m_mask = 5'h1f;
      else if (mskw)    m_mask = d[12:8];
      m_flush = ctlw && d[8];
      m_srst  = ctlw && d[9];
      if (ctlw) m_hold = d[8];
      if (ev[3]) begin m_nfield = m_field; m_field = ~m_field; end
      #1;
      chk({tag, " irq R5"}, {31'b0, irq}, {31'b0, |(m_pend & ~m_mask)});
      chk({tag, " flush R6"}, {31'b0, flush_pulse}, {31'b0, m_flush});
      chk({tag, " hold R6"}, {31'b0, draw_hold}, {31'b0, m_hold});
      chk({tag, " sreset R7"}, {31'b0, sreset_pulse}, {31'b0, m_srst});
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk);
      wr_en = 0; addr = a;
      ev_signal = 0; ev_finish = 0; hsync = 0; vsync = 0; ev_rect_done = 0;
      #1;
      chk(tag, rdata, exp_rd(a));
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 ctl after reset", rdata, 32'h551B4000);
      addr = 8'h10; #0.5;
      chk("R1 mask after reset", rdata, 32'h00007F00);
      chk("R1 outputs", {28'b0, irq, flush_pulse, sreset_pulse, draw_hold}, 32'h0);

      // R2 events latch, masked so no irq
      cyc(0, 8'h00, 0, 5'b10001, "R2 sig+rect");
      rd(8'h00, "R2 pending 0x11");
      chk("R2 literal", rdata & 32'h1F, 32'h11);
      // R5 unmask -> irq; mask keeps pending
      cyc(1, 8'h10, 32'h0, 5'b0, "R5 unmask");
      rd(8'h10, "R4 mask all clear");
      chk("R4 literal", rdata, 32'h00006000);
      cyc(1, 8'h10, 32'hFFFFFFFF, 5'b0, "R5 mask all");
      rd(8'h10, "R4 keep 12:8");
      rd(8'h00, "R5 pending kept under mask");
      cyc(1, 8'h10, 32'h00001100, 5'b0, "R4 partial");
      rd(8'h10, "R4 0x7100");
      chk("R4 literal 0x7100", rdata, 32'h00007100);
      // R3 ack semantics
      cyc(1, 8'h00, 32'h0, 5'b0, "R3 write zero");
      rd(8'h00, "R3 zero no effect");
      cyc(1, 8'h00, 32'h1, 5'b00001, "R3 collide");
      rd(8'h00, "R3 event wins");
      cyc(1, 8'h00, 32'h1F, 5'b0, "R3 ack all");
      rd(8'h00, "R3 cleared");
      chk("R3 literal", rdata & 32'h1F, 32'h0);
      // R6 flush
      cyc(1, 8'h00, 32'h100, 5'b0, "R6 flush");
      cyc(0, 8'h00, 32'h0, 5'b0, "R6 idle");
      rd(8'h00, "R6 bits 9:8 read 0");
      cyc(1, 8'h00, 32'h0, 5'b0, "R6 resume");
      // R7 soft reset
      cyc(1, 8'h10, 32'h0, 5'b00100, "R7 unmask+hsync");
      cyc(1, 8'h00, 32'h200, 5'b0, "R7 sreset");
      rd(8'h10, "R7 masks set");
      rd(8'h00, "R7 pending kept");
      // R8 field
      for (int k = 0; k < 3; k++) begin
         cyc(0, 8'h00, 0, 5'b01000, "R8 vsync");
         rd(8'h00, "R8 field bits");
      end
      // R9 fifo code
      for (int k = 0; k < 4; k++) begin
         fifo_empty = k[0]; fifo_afull = k[1];
         rd(8'h00, "R9 fifo code");
      end
      fifo_empty = 1; fifo_afull = 1;
      rd(8'h00, "R9 empty priority");
      chk("R9 literal", rdata & 32'h0000C000, 32'h00004000);
      // R10 zero words
      cyc(1, 8'h04, 32'hFFFFFFFF, 5'b0, "R10 write hi");
      rd(8'h04, "R10 hi word");
      rd(8'h20, "R10 unmapped");
      rd(8'h00, "R10 ctl unchanged");

      // random phase
      for (int k = 0; k < 3000; k++) begin
         logic [7:0] a;
         logic [4:0] ev;
         case ($urandom % 4)
            0: a = 8'h00; 1: a = 8'h10; 2: a = 8'h04; default: a = 8'h20;
         endcase
         for (int b = 0; b < 5; b++) ev[b] = ($urandom % 8) == 0;
         fifo_empty = $urandom % 2; fifo_afull = $urandom % 2;
         cyc(($urandom % 3) == 0, a, $urandom, ev, "rnd");
         if (k % 3 == 0) begin
            case ($urandom % 3)
               0: rd(8'h00, "R3 rnd ctl");
               1: rd(8'h10, "R4 rnd mask");
               default: rd(8'h04, "R10 rnd hi");
            endcase
         end
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule